// File: doc/BRIEF.md
# Dual-Channel MII Port Crossbar

This block sits between two internal PHY channels (A and B) and two MAC-side nibble ports (A and B). It steers each channel's receive stream (data nibble, data valid, receive error, carrier sense and collision) onto one port, the other port, both ports, or neither. Separately, it chooses where each channel's transmitter takes its data from: its own port, the other port, the other channel's receive stream, or nothing. Feeding one channel's receive stream into the other channel's transmitter lets the two channels act as a two-port repeater or link extender, with no MAC involved.

Each port has a master channel: channel A owns port A, and channel B owns port B. The non-master channel reaches a port's receive outputs only when the master has given that port up, either by routing to the opposite port or by being disabled. When both channels claim one port, the master's data appears there and the other channel's data is dropped for that port.

Routing codes are sampled into registers on every clock edge. The datapath is combinational from those registered codes, so a new code changes routing on the clock edge after it is presented.

Top module: `mii_port_xbar`

## Requirements
- R1: While rst_n is sampled low, the registered codes are forced to 00 for both channels, whatever the code inputs are. After reset, each channel's receive stream appears on its own port and each channel transmits from its own port.
- R2: Receive code 00 puts the channel's receive bus on its own port. The bus is the data nibble, valid, error, carrier and collision.
- R3: Receive code 01 puts the channel's receive bus on the opposite port, provided that port's master does not claim it.
- R4: Receive code 10 puts the channel's receive bus on both ports, subject to R6 on the opposite port.
- R5: Receive code 11 makes the channel drive no port. A port that no channel claims outputs all zeros on every receive signal.
- R6: A master channel claims its own port with code 00 or 10. When the master claims its port and the other channel also targets it (code 01 or 10), the port carries the master's bus.
- R7: Transmit code 00 gives the channel the data nibble, enable and error of its own port.
- R8: Transmit code 01 gives the channel the opposite port's transmit signals. The two channels' transmit codes are independent, so both channels may take from the same port while their receive routes differ.
- R9: Transmit code 10 gives the channel the other channel's receive stream: data from its receive nibble, enable from its data-valid, and error from its receive error.
- R10: Transmit code 11 presents enable 0, error 0 and data 0 to the channel.
- R11: A code presented before a clock edge has no effect on the outputs until that edge. After that edge, the outputs follow the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the code registers |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_route_cfg | input | 2x2 | Receive routing code per channel (index 0 = A, 1 = B) |
| tx_src_cfg | input | 2x2 | Transmit source code per channel |
| ch_rxd | input | 2xDATA_W | Channel receive data nibble |
| ch_rx_dv | input | 2 | Channel receive data valid |
| ch_rx_er | input | 2 | Channel receive error |
| ch_crs | input | 2 | Channel carrier sense |
| ch_col | input | 2 | Channel collision |
| port_rxd | output | 2xDATA_W | Port receive data nibble |
| port_rx_dv | output | 2 | Port receive data valid |
| port_rx_er | output | 2 | Port receive error |
| port_crs | output | 2 | Port carrier sense |
| port_col | output | 2 | Port collision |
| port_txd | input | 2xDATA_W | Port transmit data nibble from the MAC |
| port_tx_en | input | 2 | Port transmit enable |
| port_tx_er | input | 2 | Port transmit error |
| ch_txd | output | 2xDATA_W | Data nibble presented to channel transmitter |
| ch_tx_en | output | 2 | Transmit enable presented to channel |
| ch_tx_er | output | 2 | Transmit error presented to channel |

## Verification
A corrupted registered code shows up at once, in the cycle after the edge that loaded it. The affected port or channel then carries a stream from the wrong source, or zeros, and every random data pattern exposes it. A fault in ownership resolution appears only when both channels claim one port, so such pairs of codes are driven directly and also come up often under random codes. Outputs are compared twice per vector: once just before the edge that loads a new code, which exposes early or late updates, and once just after that edge.

// File: rtl/mii_xbar_pkg.sv
// Package: shared routing code types and claim decoding for the MII crossbar.
// Assumes two channels, index 0 = channel A, 1 = channel B.
package mii_xbar_pkg;

    typedef enum logic [1:0] {
        RX_OWN  = 2'b00,
        RX_OPP  = 2'b01,
        RX_BOTH = 2'b10,
        RX_OFF  = 2'b11
    } rx_route_e;

    typedef enum logic [1:0] {
        TX_OWN     = 2'b00,
        TX_OPP     = 2'b01,
        TX_PEER_RX = 2'b10,
        TX_OFF     = 2'b11
    } tx_src_e;

    // True when a receive code targets the channel's own (master) port.
    function automatic logic claims_own(input logic [1:0] code);
        return (code == RX_OWN) || (code == RX_BOTH);
    endfunction

    // True when a receive code targets the opposite port.
    function automatic logic claims_opp(input logic [1:0] code);
        return (code == RX_OPP) || (code == RX_BOTH);
    endfunction

endpackage

// File: rtl/mii_xbar_cfg.sv
// Module: registers the per-channel routing codes.
// Assumes synchronous active-low reset; reset value selects normal routing.
module mii_xbar_cfg #(
    parameter int N_CH  = 2,
    parameter int CODE_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_CH-1:0][CODE_W-1:0]  rx_route_in,
    input  logic [N_CH-1:0][CODE_W-1:0]  tx_src_in,
    output logic [N_CH-1:0][CODE_W-1:0]  rx_route_q,
    output logic [N_CH-1:0][CODE_W-1:0]  tx_src_q
);

    // Capture the codes once per clock; reset forces own-port routing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_route_q <= '0;
            tx_src_q   <= '0;
        end else begin
            rx_route_q <= rx_route_in;
            tx_src_q   <= tx_src_in;
        end
    end

    AST_CFG_RESET_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rx_route_q == '0 && tx_src_q == '0)); // R1

    AST_CFG_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_route_q == $past(rx_route_in) && tx_src_q == $past(tx_src_in))); // R11

endmodule

// File: rtl/mii_xbar_rx_arb.sv
// Module: resolves which channel drives one port's receive bus.
// Assumes the master channel is the one sharing the port's index; the master
// wins any conflict and an unclaimed port is driven to zero.
module mii_xbar_rx_arb
    import mii_xbar_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       master_route,
    input  logic [1:0]       other_route,
    input  logic [BUS_W-1:0] master_bus,
    input  logic [BUS_W-1:0] other_bus,
    output logic [BUS_W-1:0] port_bus
);

    logic master_takes;
    logic other_takes;

    // Decode whether each channel targets this port.
    always_comb begin
        master_takes = claims_own(master_route);
        other_takes  = claims_opp(other_route);
    end

    // Select the port's source with master priority, zeros when idle.
    always_comb begin
        if (master_takes)
            port_bus = master_bus;
        else if (other_takes)
            port_bus = other_bus;
        else
            port_bus = '0;
    end

    AST_MASTER_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (master_takes && other_takes) |-> (port_bus == master_bus)); // R6

    AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (master_route == RX_OPP || master_route == RX_OFF) &&
        (other_route == RX_OWN || other_route == RX_OFF) |-> (port_bus == '0)); // R5

endmodule

// File: rtl/mii_xbar_tx_sel.sv
// Module: selects the transmit source for one channel.
// Assumes peer receive data-valid maps to transmit enable in bypass mode.
module mii_xbar_tx_sel
    import mii_xbar_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src,
    input  logic [DATA_W-1:0] own_txd,
    input  logic              own_en,
    input  logic              own_er,
    input  logic [DATA_W-1:0] opp_txd,
    input  logic              opp_en,
    input  logic              opp_er,
    input  logic [DATA_W-1:0] peer_rxd,
    input  logic              peer_dv,
    input  logic              peer_er,
    output logic [DATA_W-1:0] txd,
    output logic              tx_en,
    output logic              tx_er
);

    // Multiplex the four transmit sources by code.
    always_comb begin
        unique case (src)
            TX_OWN:     begin txd = own_txd;  tx_en = own_en;  tx_er = own_er;  end
            TX_OPP:     begin txd = opp_txd;  tx_en = opp_en;  tx_er = opp_er;  end
            TX_PEER_RX: begin txd = peer_rxd; tx_en = peer_dv; tx_er = peer_er; end
            default:    begin txd = '0;       tx_en = 1'b0;    tx_er = 1'b0;    end
        endcase
    end

    AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src == TX_OFF) |-> (!tx_en && !tx_er)); // R10

    AST_TX_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (src == TX_PEER_RX) |-> (tx_en == peer_dv && txd == peer_rxd)); // R9

endmodule

// File: rtl/mii_port_xbar.sv
// Module: dual-channel MII port crossbar top.
// Registers routing codes, then routes receive buses to ports with master
// ownership and transmit buses to channels. Index 0 = A, 1 = B.
module mii_port_xbar #(
    parameter int DATA_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0][1:0]        rx_route_cfg,
    input  logic [1:0][1:0]        tx_src_cfg,
    input  logic [1:0][DATA_W-1:0] ch_rxd,
    input  logic [1:0]             ch_rx_dv,
    input  logic [1:0]             ch_rx_er,
    input  logic [1:0]             ch_crs,
    input  logic [1:0]             ch_col,
    output logic [1:0][DATA_W-1:0] port_rxd,
    output logic [1:0]             port_rx_dv,
    output logic [1:0]             port_rx_er,
    output logic [1:0]             port_crs,
    output logic [1:0]             port_col,
    input  logic [1:0][DATA_W-1:0] port_txd,
    input  logic [1:0]             port_tx_en,
    input  logic [1:0]             port_tx_er,
    output logic [1:0][DATA_W-1:0] ch_txd,
    output logic [1:0]             ch_tx_en,
    output logic [1:0]             ch_tx_er
);

    localparam int N_CH   = 2;
    localparam int CODE_W = 2;
    localparam int RXB_W  = DATA_W + 4;

    logic [N_CH-1:0][CODE_W-1:0] rx_route_q;
    logic [N_CH-1:0][CODE_W-1:0] tx_src_q;
    logic [N_CH-1:0][RXB_W-1:0]  ch_bus;
    logic [N_CH-1:0][RXB_W-1:0]  pt_bus;

    mii_xbar_cfg #(.N_CH(N_CH), .CODE_W(CODE_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_route_in (rx_route_cfg),
        .tx_src_in   (tx_src_cfg),
        .rx_route_q  (rx_route_q),
        .tx_src_q    (tx_src_q)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_lane
        localparam int OPP = N_CH - 1 - i;

        // Pack the channel receive signals into one bus.
        always_comb ch_bus[i] = {ch_rxd[i], ch_rx_dv[i], ch_rx_er[i], ch_crs[i], ch_col[i]};

        mii_xbar_rx_arb #(.BUS_W(RXB_W)) u_rx_arb (
            .clk          (clk),
            .rst_n        (rst_n),
            .master_route (rx_route_q[i]),
            .other_route  (rx_route_q[OPP]),
            .master_bus   (ch_bus[i]),
            .other_bus    (ch_bus[OPP]),
            .port_bus     (pt_bus[i])
        );

        // Unpack the resolved port bus onto the port outputs.
        always_comb {port_rxd[i], port_rx_dv[i], port_rx_er[i], port_crs[i], port_col[i]} = pt_bus[i];

        mii_xbar_tx_sel #(.DATA_W(DATA_W)) u_tx_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (tx_src_q[i]),
            .own_txd  (port_txd[i]),
            .own_en   (port_tx_en[i]),
            .own_er   (port_tx_er[i]),
            .opp_txd  (port_txd[OPP]),
            .opp_en   (port_tx_en[OPP]),
            .opp_er   (port_tx_er[OPP]),
            .peer_rxd (ch_rxd[OPP]),
            .peer_dv  (ch_rx_dv[OPP]),
            .peer_er  (ch_rx_er[OPP]),
            .txd      (ch_txd[i]),
            .tx_en    (ch_tx_en[i]),
            .tx_er    (ch_tx_er[i])
        );
    end

    AST_OWN_PORT_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_route_q[0] == 2'b00) |-> (port_rxd[0] == ch_rxd[0] && port_rx_dv[0] == ch_rx_dv[0])); // R2

    AST_BOTH_PORTS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_route_q[1] == 2'b10 && rx_route_q[0] != 2'b00 && rx_route_q[0] != 2'b10)
        |-> (port_crs[0] == ch_crs[1] && port_crs[1] == ch_crs[1])); // R4

endmodule

// File: tb/mii_port_xbar_bench.sv
// Bench: directed corners plus seeded random codes and data, each vector
// checked just before and just after the edge that loads new codes.
module mii_port_xbar_bench;

    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0][1:0]    rx_route_cfg, tx_src_cfg;
    logic [1:0][DW-1:0] ch_rxd, port_rxd, port_txd, ch_txd;
    logic [1:0] ch_rx_dv, ch_rx_er, ch_crs, ch_col;
    logic [1:0] port_rx_dv, port_rx_er, port_crs, port_col;
    logic [1:0] port_tx_en, port_tx_er, ch_tx_en, ch_tx_er;

    logic [1:0][1:0] m_rx, m_tx;
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mii_port_xbar #(.DATA_W(DW)) u_mii_port_xbar (
        .clk(clk), .rst_n(rst_n),
        .rx_route_cfg(rx_route_cfg), .tx_src_cfg(tx_src_cfg),
        .ch_rxd(ch_rxd), .ch_rx_dv(ch_rx_dv), .ch_rx_er(ch_rx_er),
        .ch_crs(ch_crs), .ch_col(ch_col),
        .port_rxd(port_rxd), .port_rx_dv(port_rx_dv), .port_rx_er(port_rx_er),
        .port_crs(port_crs), .port_col(port_col),
        .port_txd(port_txd), .port_tx_en(port_tx_en), .port_tx_er(port_tx_er),
        .ch_txd(ch_txd), .ch_tx_en(ch_tx_en), .ch_tx_er(ch_tx_er)
    );

    function automatic logic [DW+3:0] rx_of_ch(input int c);
        return {ch_rxd[c], ch_rx_dv[c], ch_rx_er[c], ch_crs[c], ch_col[c]};
    endfunction

    function automatic logic [DW+3:0] exp_port(input int p);
        int o = 1 - p;
        logic m_take = (m_rx[p] == 2'b00) || (m_rx[p] == 2'b10);
        logic o_take = (m_rx[o] == 2'b01) || (m_rx[o] == 2'b10);
        if (m_take) return rx_of_ch(p);
        if (o_take) return rx_of_ch(o);
        return '0;
    endfunction

    function automatic string rx_tag(input int p);
        int o = 1 - p;
        logic m_take = (m_rx[p] == 2'b00) || (m_rx[p] == 2'b10);
        logic o_take = (m_rx[o] == 2'b01) || (m_rx[o] == 2'b10);
        if (m_take && o_take) return "R6";
        if (m_take) return (m_rx[p] == 2'b00) ? "R2" : "R4";
        if (o_take) return (m_rx[o] == 2'b01) ? "R3" : "R4";
        return "R5";
    endfunction

    function automatic logic [DW+1:0] exp_tx(input int c);
        int o = 1 - c;
        case (m_tx[c])
            2'b00:   return {port_txd[c], port_tx_en[c], port_tx_er[c]};
            2'b01:   return {port_txd[o], port_tx_en[o], port_tx_er[o]};
            2'b10:   return {ch_rxd[o], ch_rx_dv[o], ch_rx_er[o]};
            default: return '0;
        endcase
    endfunction

    function automatic string tx_tag(input int c);
        case (m_tx[c])
            2'b00:   return "R7";
            2'b01:   return "R8";
            2'b10:   return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string force_tag);
        for (int p = 0; p < 2; p++) begin
            string t1 = (force_tag != "") ? force_tag : rx_tag(p);
            string t2 = (force_tag != "") ? force_tag : tx_tag(p);
            check(t1, 32'({port_rxd[p], port_rx_dv[p], port_rx_er[p], port_crs[p], port_col[p]}),
                  32'(exp_port(p)));
            check(t2, 32'({ch_txd[p], ch_tx_en[p], ch_tx_er[p]}), 32'(exp_tx(p)));
        end
    endtask

    task automatic rand_data();
        ch_rxd   = 8'($urandom);
        ch_rx_dv = 2'($urandom); ch_rx_er = 2'($urandom);
        ch_crs   = 2'($urandom); ch_col   = 2'($urandom);
        port_txd = 8'($urandom);
        port_tx_en = 2'($urandom); port_tx_er = 2'($urandom);
    endtask

    // One vector: new codes and data, check old routing, then new routing.
    task automatic run_vec(input logic [1:0][1:0] rx_c, input logic [1:0][1:0] tx_c);
        @(negedge clk);
        rx_route_cfg = rx_c;
        tx_src_cfg   = tx_c;
        rand_data();
        #2;
        check_all((rx_c != m_rx || tx_c != m_tx) ? "R11" : "");
        @(posedge clk);
        #2;
        m_rx = rx_c;
        m_tx = tx_c;
        check_all("");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'd20240611);
        rx_route_cfg = '1;
        tx_src_cfg   = '1;
        rand_data();
        m_rx = '0;
        m_tx = '0;
        repeat (3) @(posedge clk);
        #2;
        // R1: codes held at all-ones during reset must not be taken.
        check_all("R1");
        @(negedge clk);
        rx_route_cfg = '0;
        tx_src_cfg   = '0;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_all("R1");

        // Directed corners.
        run_vec({2'b10, 2'b10}, {2'b00, 2'b00}); // R6 both claim both ports
        run_vec({2'b11, 2'b11}, {2'b11, 2'b11}); // R5, R10 all disabled
        run_vec({2'b01, 2'b01}, {2'b01, 2'b01}); // R3 swap, R8 swap
        run_vec({2'b00, 2'b01}, {2'b01, 2'b00}); // R8 both from port A
        run_vec({2'b00, 2'b01}, {2'b10, 2'b10}); // R6 master wins, R9 bypass
        run_vec({2'b11, 2'b10}, {2'b10, 2'b11}); // R4 both ports, R9
        run_vec({2'b00, 2'b00}, {2'b00, 2'b00}); // R2, R7

        for (int k = 0; k < 400; k++)
            run_vec(4'($urandom), 4'($urandom));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule